// File: doc/BRIEF.md
# Fast-to-14MHz Bus Cycle Synchronizer

This block sits on a processor accelerator card. It lets a fast processor run bus cycles against a motherboard whose cycle controller samples on the rising edge of a 14 MHz system clock. The state machine runs on the falling edge of that same clock. It turns each main-board request from the processor into address and data strobes with 14 MHz timing, and waits for the motherboard's acknowledge lines. It then releases the strobes, latches read data and hands the acknowledge pattern back to the processor.

Cycles that an address-range compare marks as local to the card never reach the motherboard strobes, so the motherboard sees only idle time while they run. After every main-board cycle, a one-shot keeps the next cycle from starting for a set number of falling edges. This keeps a slow-releasing acknowledge from ending that next cycle early.

A separate path re-registers the motherboard's interrupt priority lines on a color-clock strobe. Every line then changes on the same edge before the processor samples them.

Top module: `fastbus_sync`

## Requirements
- R1: After reset, `mb_as_n` and `mb_ds_n` are 1, `cpu_ack_n` is all ones, `cpu_ipl_n` is all ones and `cpu_data` is 0.
- R2: A falling edge that samples `cpu_as_n`=0, `cpu_local`=0 and `cpu_rw`=1 (read) drives `mb_as_n` and `mb_ds_n` low together after that edge.
- R3: For a write (`cpu_rw`=0), `mb_as_n` goes low after the starting edge and `mb_ds_n` goes low one falling edge later. `mb_ds_n` is never low while `mb_as_n` is high.
- R4: While the strobes are asserted, the first falling edge that samples any `mb_ack_n` bit at 0 captures the whole `mb_ack_n` pattern. On the next falling edge, both strobes return to 1 together and `cpu_ack_n` takes the captured pattern. Any pattern is relayed unchanged, including bus-error or halt bits (for example 4'b1011 or 4'b0011) and the two-bit acknowledge 4'b1100.
- R5: On a read, `cpu_data` takes the `mb_data` value present at the falling edge that releases the strobes. It holds that value while `cpu_ack_n` is asserted and until the next read captures new data. Writes and local cycles leave it unchanged.
- R6: `cpu_ack_n` keeps the relayed pattern until a falling edge samples `cpu_as_n`=1. After that edge it is all ones.
- R7: After the edge that releases the strobes, no new main-board cycle asserts `mb_as_n` within SUPPRESS further falling edges. As a result, an acknowledge still held low from the previous cycle cannot end the next cycle.
- R8: Between consecutive main-board cycles, `mb_as_n` stays 1 for at least two falling edges, so it spans at least one rising edge.
- R9: While `cpu_local`=1, a cycle asserts neither motherboard strobe and leaves `cpu_ack_n` all ones.
- R10: On a rising clock edge with `cck_en`=1, `cpu_ipl_n` takes `ipl_in_n`. On rising edges with `cck_en`=0 it holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 14 MHz system clock; the state machine uses its falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_as_n | input | 1 | Fast processor address strobe, active low |
| cpu_rw | input | 1 | Cycle direction, 1 = read, 0 = write |
| cpu_local | input | 1 | Address compare result, 1 = card-local target |
| mb_ack_n | input | ACK_W | Motherboard acknowledge, bus error and halt lines, active low |
| mb_data | input | DATA_W | Motherboard read data |
| ipl_in_n | input | IPL_W | Motherboard interrupt priority lines |
| cck_en | input | 1 | Color-clock rising-edge strobe |
| mb_as_n | output | 1 | Address strobe to the motherboard |
| mb_ds_n | output | 1 | Data strobe to the motherboard |
| cpu_ack_n | output | ACK_W | Acknowledge pattern relayed to the processor |
| cpu_data | output | DATA_W | Latched read data to the processor |
| cpu_ipl_n | output | IPL_W | Re-registered interrupt priority lines |

## Verification
The bench builds the block with DATA_W=16, ACK_W=4, IPL_W=3, SUPPRESS=3 and the re-registered interrupt variant. With a three-edge one-shot, the bench can hold a stale acknowledge low across the start of a back-to-back cycle, then show that the new strobe is delayed past it and the cycle keeps waiting. Four acknowledge lines allow single-line, two-line, bus-error and halt patterns to be relayed and compared bit for bit. A 16-bit data path keeps the distinct read values easy to tell apart from the data held through writes and local cycles.

// File: rtl/fastbus_sync_pkg.sv
package fastbus_sync_pkg;
   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_WDS  = 3'd1,
      ST_WAIT = 3'd2,
      ST_TERM = 3'd3,
      ST_HOLD = 3'd4
   } cyc_state_t;
endpackage

// File: rtl/fastbus_sync_fsm.sv
module fastbus_sync_fsm
   import fastbus_sync_pkg::*;
#(
   parameter int ACK_W    = 4,
   parameter int SUPPRESS = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cpu_as_n,
   input  logic             cpu_rw,
   input  logic             cpu_local,
   input  logic [ACK_W-1:0] mb_ack_n,
   output logic             mb_as_n,
   output logic             mb_ds_n,
   output logic [ACK_W-1:0] cpu_ack_n,
   output logic             latch_en
);
   localparam int GAP_W = $clog2(SUPPRESS + 1);

   cyc_state_t       state;
   logic [GAP_W-1:0] gap_cnt;
   logic [ACK_W-1:0] code_q;
   logic             rd_q;

   // read data is captured on the same edge that releases the strobes
   assign latch_en = (state == ST_TERM) && rd_q;

   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         gap_cnt   <= '0;
         code_q    <= '1;
         rd_q      <= 1'b1;
         mb_as_n   <= 1'b1;
         mb_ds_n   <= 1'b1;
         cpu_ack_n <= '1;
      end else begin
         case (state)
            ST_IDLE: begin
               if (gap_cnt != '0) begin
                  gap_cnt <= gap_cnt - 1'b1;
               end else if (!cpu_as_n && !cpu_local) begin
                  mb_as_n <= 1'b0;
                  rd_q    <= cpu_rw;
                  if (cpu_rw) begin
                     mb_ds_n <= 1'b0;
                     state   <= ST_WAIT;
                  end else begin
                     state   <= ST_WDS;
                  end
               end
            end
            ST_WDS: begin
               mb_ds_n <= 1'b0;
               state   <= ST_WAIT;
            end
            ST_WAIT: begin
               if (~&mb_ack_n) begin
                  code_q <= mb_ack_n;
                  state  <= ST_TERM;
               end
            end
            ST_TERM: begin
               mb_as_n   <= 1'b1;
               mb_ds_n   <= 1'b1;
               cpu_ack_n <= code_q;
               gap_cnt   <= GAP_W'(SUPPRESS);
               state     <= ST_HOLD;
            end
            ST_HOLD: begin
               if (gap_cnt != '0) gap_cnt <= gap_cnt - 1'b1;
               if (cpu_as_n) begin
                  cpu_ack_n <= '1;
                  state     <= ST_IDLE;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/fastbus_sync_rdlatch.sv
module fastbus_sync_rdlatch #(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              latch_en,
   input  logic [DATA_W-1:0] mb_data,
   output logic [DATA_W-1:0] cpu_data
);
   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n)        cpu_data <= '0;
      else if (latch_en) cpu_data <= mb_data;
   end
endmodule

// File: rtl/fastbus_sync_ipl.sv
module fastbus_sync_ipl #(
   parameter int IPL_W      = 3,
   parameter bit IPL_RESYNC = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cck_en,
   input  logic [IPL_W-1:0] ipl_in_n,
   output logic [IPL_W-1:0] cpu_ipl_n
);
   generate
      if (IPL_RESYNC) begin : g_resync
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      cpu_ipl_n <= '1;
            else if (cck_en) cpu_ipl_n <= ipl_in_n;
         end
      end else begin : g_pass
         assign cpu_ipl_n = ipl_in_n;
      end
   endgenerate
endmodule

// File: rtl/fastbus_sync.sv
module fastbus_sync #(
   parameter int DATA_W     = 32,
   parameter int ACK_W      = 4,
   parameter int IPL_W      = 3,
   parameter int SUPPRESS   = 2,
   parameter bit IPL_RESYNC = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_as_n,
   input  logic              cpu_rw,
   input  logic              cpu_local,
   input  logic [ACK_W-1:0]  mb_ack_n,
   input  logic [DATA_W-1:0] mb_data,
   input  logic [IPL_W-1:0]  ipl_in_n,
   input  logic              cck_en,
   output logic              mb_as_n,
   output logic              mb_ds_n,
   output logic [ACK_W-1:0]  cpu_ack_n,
   output logic [DATA_W-1:0] cpu_data,
   output logic [IPL_W-1:0]  cpu_ipl_n
);
   generate
      if (SUPPRESS < 1)  $error("SUPPRESS must be at least 1");
      if (ACK_W < 1)     $error("ACK_W must be at least 1");
      if (DATA_W < 1)    $error("DATA_W must be at least 1");
      if (IPL_W < 1)     $error("IPL_W must be at least 1");
   endgenerate

   logic latch_en;

   fastbus_sync_fsm #(.ACK_W(ACK_W), .SUPPRESS(SUPPRESS)) u_fsm (
      .clk(clk), .rst_n(rst_n), .cpu_as_n(cpu_as_n), .cpu_rw(cpu_rw),
      .cpu_local(cpu_local), .mb_ack_n(mb_ack_n), .mb_as_n(mb_as_n),
      .mb_ds_n(mb_ds_n), .cpu_ack_n(cpu_ack_n), .latch_en(latch_en)
   );

   fastbus_sync_rdlatch #(.DATA_W(DATA_W)) u_lat (
      .clk(clk), .rst_n(rst_n), .latch_en(latch_en),
      .mb_data(mb_data), .cpu_data(cpu_data)
   );

   fastbus_sync_ipl #(.IPL_W(IPL_W), .IPL_RESYNC(IPL_RESYNC)) u_ipl (
      .clk(clk), .rst_n(rst_n), .cck_en(cck_en),
      .ipl_in_n(ipl_in_n), .cpu_ipl_n(cpu_ipl_n)
   );
endmodule

// File: rtl/fastbus_sync_chk.sv
module fastbus_sync_chk #(
   parameter int DATA_W     = 32,
   parameter int ACK_W      = 4,
   parameter int IPL_W      = 3,
   parameter bit IPL_RESYNC = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cpu_as_n,
   input logic              cpu_rw,
   input logic              cpu_local,
   input logic [IPL_W-1:0]  ipl_in_n,
   input logic              cck_en,
   input logic              mb_as_n,
   input logic              mb_ds_n,
   input logic [ACK_W-1:0]  cpu_ack_n,
   input logic [DATA_W-1:0] cpu_data,
   input logic [IPL_W-1:0]  cpu_ipl_n
);
   // R2
   rd_strobe_pair_chk: assert property (@(negedge clk) disable iff (!rst_n)
      ($fell(mb_as_n) && $past(cpu_rw)) |-> !mb_ds_n);

   // R3
   wr_ds_late_chk: assert property (@(negedge clk) disable iff (!rst_n)
      ($fell(mb_as_n) && !$past(cpu_rw)) |-> (mb_ds_n ##1 !mb_ds_n));

   // R3
   ds_inside_as_chk: assert property (@(negedge clk) disable iff (!rst_n)
      mb_as_n |-> mb_ds_n);

   // R4
   release_with_ack_chk: assert property (@(negedge clk) disable iff (!rst_n)
      $rose(mb_as_n) |-> (mb_ds_n && !(&cpu_ack_n)));

   // R5
   data_hold_chk: assert property (@(negedge clk) disable iff (!rst_n)
      (!(&cpu_ack_n) && !(&$past(cpu_ack_n))) |-> $stable(cpu_data));

   // R6
   ack_release_chk: assert property (@(negedge clk) disable iff (!rst_n)
      (!(&$past(cpu_ack_n)) && $past(cpu_as_n)) |-> (&cpu_ack_n));

   // R8
   idle_gap_chk: assert property (@(negedge clk) disable iff (!rst_n)
      $rose(mb_as_n) |=> mb_as_n);

   // R9
   local_quiet_chk: assert property (@(negedge clk) disable iff (!rst_n)
      ($past(mb_as_n) && $past(cpu_local)) |-> mb_as_n);

   generate
      if (IPL_RESYNC) begin : g_ipl_chk
         // R10
         ipl_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
            cck_en |=> (cpu_ipl_n == $past(ipl_in_n)));
         // R10
         ipl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !cck_en |=> $stable(cpu_ipl_n));
      end
   endgenerate
endmodule

bind fastbus_sync fastbus_sync_chk #(
   .DATA_W(DATA_W), .ACK_W(ACK_W), .IPL_W(IPL_W), .IPL_RESYNC(IPL_RESYNC)
) u_chk (.*);

// File: tb/sim_fastbus_sync.sv
module sim_fastbus_sync;
   localparam int DW = 16;
   localparam int AW = 4;
   localparam int IW = 3;
   localparam int SUP = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cpu_as_n = 1'b1;
   logic          cpu_rw = 1'b1;
   logic          cpu_local = 1'b0;
   logic [AW-1:0] mb_ack_n = '1;
   logic [DW-1:0] mb_data = '0;
   logic [IW-1:0] ipl_in_n = '1;
   logic          cck_en = 1'b0;
   logic          mb_as_n, mb_ds_n;
   logic [AW-1:0] cpu_ack_n;
   logic [DW-1:0] cpu_data;
   logic [IW-1:0] cpu_ipl_n;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   fastbus_sync #(.DATA_W(DW), .ACK_W(AW), .IPL_W(IW), .SUPPRESS(SUP),
                  .IPL_RESYNC(1'b1)) u0 (
      .clk(clk), .rst_n(rst_n), .cpu_as_n(cpu_as_n), .cpu_rw(cpu_rw),
      .cpu_local(cpu_local), .mb_ack_n(mb_ack_n), .mb_data(mb_data),
      .ipl_in_n(ipl_in_n), .cck_en(cck_en), .mb_as_n(mb_as_n),
      .mb_ds_n(mb_ds_n), .cpu_ack_n(cpu_ack_n), .cpu_data(cpu_data),
      .cpu_ipl_n(cpu_ipl_n)
   );

   task automatic tick();
      @(negedge clk);
      #1;
   endtask

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic chk_strobes(input string req, input logic as_e, input logic ds_e);
      chk(mb_as_n == as_e && mb_ds_n == ds_e, req, {mb_as_n, mb_ds_n}, {as_e, ds_e});
   endtask

   task automatic idle_gap();
      for (int i = 0; i < SUP + 2; i++) tick();
   endtask

   // read cycle: waits 'w' edges, then acknowledges with 'code'
   task automatic t_read(input logic [DW-1:0] d, input logic [AW-1:0] code, input int w);
      cpu_rw = 1'b1; cpu_local = 1'b0; cpu_as_n = 1'b0;
      tick();
      chk_strobes("R2 read strobes", 1'b0, 1'b0);
      mb_data = d;
      for (int i = 0; i < w; i++) begin
         tick();
         chk(mb_as_n == 1'b0 && &cpu_ack_n, "R4 waiting", {mb_as_n, cpu_ack_n}, {1'b0, {AW{1'b1}}});
      end
      mb_ack_n = code;
      tick();
      chk_strobes("R4 strobes held on sample edge", 1'b0, 1'b0);
      mb_ack_n = '1;
      mb_data = ~d;
      tick();
      chk_strobes("R4 release", 1'b1, 1'b1);
      chk(cpu_ack_n == code, "R4 ack pattern", cpu_ack_n, code);
      chk(cpu_data == ~d, "R5 read data", cpu_data, ~d);
      tick();
      chk(cpu_ack_n == code, "R6 ack held", cpu_ack_n, code);
      cpu_as_n = 1'b1;
      tick();
      chk(&cpu_ack_n, "R6 ack released", cpu_ack_n, {AW{1'b1}});
      chk(cpu_data == ~d, "R5 data held", cpu_data, ~d);
      idle_gap();
   endtask

   task automatic t_write(input logic [AW-1:0] code, input logic [DW-1:0] prev);
      cpu_rw = 1'b0; cpu_local = 1'b0; cpu_as_n = 1'b0;
      mb_data = 16'hDEAD;
      tick();
      chk_strobes("R3 write as first", 1'b0, 1'b1);
      mb_ack_n = code;
      tick();
      chk_strobes("R3 write ds next edge", 1'b0, 1'b0);
      tick();
      chk_strobes("R4 write sample edge", 1'b0, 1'b0);
      mb_ack_n = '1;
      tick();
      chk_strobes("R4 write release", 1'b1, 1'b1);
      chk(cpu_ack_n == code, "R4 write ack pattern", cpu_ack_n, code);
      chk(cpu_data == prev, "R5 write leaves data", cpu_data, prev);
      cpu_as_n = 1'b1;
      tick();
      chk(&cpu_ack_n, "R6 write ack released", cpu_ack_n, {AW{1'b1}});
      idle_gap();
   endtask

   task automatic t_local(input logic [DW-1:0] prev);
      cpu_rw = 1'b1; cpu_local = 1'b1; cpu_as_n = 1'b0;
      mb_ack_n = 4'b1110;
      mb_data = 16'hBEEF;
      for (int i = 0; i < 4; i++) begin
         tick();
         chk_strobes("R9 local no strobes", 1'b1, 1'b1);
         chk(&cpu_ack_n, "R9 local no ack", cpu_ack_n, {AW{1'b1}});
      end
      chk(cpu_data == prev, "R5 local leaves data", cpu_data, prev);
      cpu_as_n = 1'b1; cpu_local = 1'b0; mb_ack_n = '1;
      idle_gap();
   endtask

   // back-to-back read with an acknowledge left low after release
   task automatic t_stale();
      int gap;
      cpu_rw = 1'b1; cpu_local = 1'b0; cpu_as_n = 1'b0;
      tick();
      mb_data = 16'h1234;
      mb_ack_n = 4'b1110;
      tick();
      tick();
      chk_strobes("R4 stale-test release", 1'b1, 1'b1);
      cpu_as_n = 1'b1;
      tick();
      chk(&cpu_ack_n, "R6 stale-test ack released", cpu_ack_n, {AW{1'b1}});
      cpu_as_n = 1'b0;
      gap = 1;
      while (mb_as_n && gap < 10) begin
         tick();
         gap++;
         if (gap == SUP) mb_ack_n = '1;
      end
      chk(gap == SUP + 1, "R7 one-shot delay", gap, SUP + 1);
      chk(gap >= 2, "R8 idle gap", gap, 2);
      tick();
      chk(mb_as_n == 1'b0 && &cpu_ack_n, "R7 stale ack ignored",
          {mb_as_n, cpu_ack_n}, {1'b0, {AW{1'b1}}});
      mb_data = 16'h5678;
      mb_ack_n = 4'b1101;
      tick();
      mb_ack_n = '1;
      tick();
      chk(cpu_ack_n == 4'b1101, "R4 second cycle ack", cpu_ack_n, 4'b1101);
      chk(cpu_data == 16'h5678, "R5 second cycle data", cpu_data, 16'h5678);
      cpu_as_n = 1'b1;
      tick();
      idle_gap();
   endtask

   task automatic t_ipl();
      ipl_in_n = 3'b010; cck_en = 1'b0;
      tick();
      chk(cpu_ipl_n == 3'b111, "R10 ipl hold without strobe", cpu_ipl_n, 3'b111);
      cck_en = 1'b1;
      tick();
      chk(cpu_ipl_n == 3'b010, "R10 ipl load", cpu_ipl_n, 3'b010);
      cck_en = 1'b0; ipl_in_n = 3'b101;
      tick();
      chk(cpu_ipl_n == 3'b010, "R10 ipl hold after change", cpu_ipl_n, 3'b010);
      cck_en = 1'b1;
      tick();
      chk(cpu_ipl_n == 3'b101, "R10 ipl second load", cpu_ipl_n, 3'b101);
      cck_en = 1'b0;
   endtask

   initial begin
      tick();
      tick();
      rst_n = 1'b1;
      tick();
      // R1
      chk_strobes("R1 reset strobes", 1'b1, 1'b1);
      chk(&cpu_ack_n, "R1 reset ack", cpu_ack_n, {AW{1'b1}});
      chk(&cpu_ipl_n, "R1 reset ipl", cpu_ipl_n, {IW{1'b1}});
      chk(cpu_data == '0, "R1 reset data", cpu_data, 0);
      t_read(16'hA5C3, 4'b1110, 2);
      t_read(16'h0F0F, 4'b1011, 0);
      t_write(4'b1100, 16'hF0F0);
      t_local(16'hF0F0);
      t_read(16'h3C3C, 4'b0011, 3);
      t_stale();
      t_ipl();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #100000;
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule